// File: doc/BRIEF.md
# Charge Pump Gain Selection Controller

This controller chooses between the two gains of an LED-driver charge pump: pass mode (1x) and boost (3/2x). Each current-sink pin has an analog comparator that raises a flag when the voltage across the sink drops to about 175 mV, which means it is running short of headroom. The controller keeps only the flags of sinks that are currently driven. It requires a flag to persist before it raises the gain, and it lowers the gain again only after a clear period. The pump runs whenever at least one of the two monitored LED banks is enabled.

Bank A has five sinks and bank B has three. Each bank has its own enable. The fifth bank-A sink has a separate sense enable, because that pin may be unused and tied to ground. The third bank-B sink has an enable that switches its driver and its sensing together, and it may be changed while the pump runs. The indicator sink has no flag input, so it can never influence the gain.

The control is a five-state machine:
- OFF: the pump is stopped.
- PASS: 1x, no candidate flag.
- RISE_QUAL: 1x, a monitored flag is being qualified.
- BOOST: 3/2x.
- FALL_QUAL: 3/2x, all flags clear and the dwell is being timed.

The transitions are:
- Enable: OFF→PASS.
- Flag seen: PASS→RISE_QUAL or BOOST.
- Qualified: RISE_QUAL→BOOST.
- Glitch: RISE_QUAL→PASS.
- Clear seen: BOOST→FALL_QUAL or PASS.
- Dwell done: FALL_QUAL→PASS.
- Re-flag: FALL_QUAL→BOOST.
- Set change: any active state→PASS.
- Disable: any state→OFF.

Top module: `pump_gain_ctrl`

## Requirements
- R1: While rst_n is low, pump_on is 0 and gain_boost is 0. This holds at the first falling clock edge after rst_n falls, and it holds whatever the inputs are.
- R2: pump_on is 1 exactly from the first clock edge after en_bank_a or en_bank_b becomes 1. It returns to 0 at the first clock edge after both are 0, and gain_boost is then 0. After an enable, the gain starts at 1x.
- R3: From 1x, gain_boost becomes 1 at the clock edge on which a monitored flag has been sampled high on rise_count consecutive edges (any flag counts). A shorter burst leaves the gain at 1x.
- R4: From 3/2x, gain_boost returns to 0 at the clock edge on which all monitored flags have been sampled low on fall_count consecutive edges. Any monitored flag during this dwell restarts it, and the gain stays at 3/2x.
- R5: Flags sink_low_a[4:0] count only while en_bank_a is 1. Flags sink_low_b[2:0] count only while en_bank_b is 1.
- R6: sink_low_a[4] counts only while en_sense_a5 is 1, in addition to the condition in R5.
- R7: sink_low_b[2] counts only while en_pin_b3 is 1, in addition to the condition in R5.
- R8: When the set of monitored pins changes while the pump is on, the controller goes back to 1x at that edge and clears its qualification count. It then re-qualifies the flags from the next edge.
- R9: A rise_count or fall_count of 0 behaves as 1, so a single sample is enough to switch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_bank_a | input | 1 | Bank A driver enable |
| en_bank_b | input | 1 | Bank B driver enable |
| en_sense_a5 | input | 1 | Sense enable for the fifth bank-A pin |
| en_pin_b3 | input | 1 | Driver and sense enable for the third bank-B pin |
| sink_low_a | input | 5 | Low-headroom flags of the bank-A sinks |
| sink_low_b | input | 3 | Low-headroom flags of the bank-B sinks |
| rise_count | input | 8 | Consecutive flagged samples needed to enter 3/2x |
| fall_count | input | 8 | Consecutive clear samples needed to return to 1x |
| gain_boost | output | 1 | 1 = 3/2x, 0 = 1x |
| pump_on | output | 1 | Charge pump running |

## Verification
The hardest case to reach is a change in the monitored set that arrives in the middle of a dwell or a qualification. It has to land while a count is partly advanced and the gain is boosted, so that the forced return to 1x can be told apart from an ordinary timeout. The stimulus first brings the pump to 3/2x with a long fall_count. It then clears the flags for a few cycles and flips en_pin_b3 or en_sense_a5 before the dwell ends. A behavioural model tracks runs of consecutive samples and the previous monitored set, and it is compared with both outputs on every cycle.

// File: rtl/pgc_pkg.sv
package pgc_pkg;
    typedef enum logic [2:0] {
        ST_OFF       = 3'd0,
        ST_PASS      = 3'd1,
        ST_RISE_QUAL = 3'd2,
        ST_BOOST     = 3'd3,
        ST_FALL_QUAL = 3'd4
    } pgc_state_t;
endpackage

// File: rtl/pgc_sense_mask.sv
module pgc_sense_mask #(
    parameter int NUM_A = 5,
    parameter int NUM_B = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_bank_a,
    input  logic             en_bank_b,
    input  logic             en_sense_a5,
    input  logic             en_pin_b3,
    input  logic [NUM_A-1:0] sink_low_a,
    input  logic [NUM_B-1:0] sink_low_b,
    output logic             mon_any,
    output logic             set_change
);
    localparam int NUM_ALL = NUM_A + NUM_B;

    logic [NUM_ALL-1:0] watch;
    logic [NUM_ALL-1:0] watch_q;
    logic [NUM_ALL-1:0] flags;

    // Per-pin watch enable; the last pin of each bank has its own extra gate.
    for (genvar i = 0; i < NUM_A; i++) begin : g_a
        if (i == NUM_A - 1) begin : g_last
            assign watch[i] = en_bank_a & en_sense_a5;
        end else begin : g_plain
            assign watch[i] = en_bank_a;
        end
        assign flags[i] = sink_low_a[i] & watch[i];
    end
    for (genvar j = 0; j < NUM_B; j++) begin : g_b
        if (j == NUM_B - 1) begin : g_last
            assign watch[NUM_A+j] = en_bank_b & en_pin_b3;
        end else begin : g_plain
            assign watch[NUM_A+j] = en_bank_b;
        end
        assign flags[NUM_A+j] = sink_low_b[j] & watch[NUM_A+j];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) watch_q <= '0;
        else        watch_q <= watch;
    end

    assign mon_any    = |flags;
    assign set_change = (watch != watch_q);
endmodule

// File: rtl/pgc_qual_cnt.sv
module pgc_qual_cnt #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          inc,
    input  logic [CW-1:0] limit,
    output logic          hit
);
    logic [CW-1:0] cnt;
    logic [CW:0]   lim_eff;
    logic [CW:0]   next_val;

    assign lim_eff  = (limit == '0) ? {{CW{1'b0}}, 1'b1} : {1'b0, limit};
    assign next_val = {1'b0, cnt} + {{CW{1'b0}}, 1'b1};
    assign hit      = (next_val >= lim_eff);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cnt <= '0;
        else if (clr) cnt <= '0;
        else if (inc) cnt <= next_val[CW-1:0];
    end
endmodule

// File: rtl/pump_gain_ctrl.sv
module pump_gain_ctrl
    import pgc_pkg::*;
#(
    parameter int NUM_A = 5,
    parameter int NUM_B = 3,
    parameter int CW    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_bank_a,
    input  logic             en_bank_b,
    input  logic             en_sense_a5,
    input  logic             en_pin_b3,
    input  logic [NUM_A-1:0] sink_low_a,
    input  logic [NUM_B-1:0] sink_low_b,
    input  logic [CW-1:0]    rise_count,
    input  logic [CW-1:0]    fall_count,
    output logic             gain_boost,
    output logic             pump_on
);
    pgc_state_t state, state_nx;
    logic       mon_any, set_change, en_any;
    logic       cnt_clr, cnt_inc, cnt_hit;
    logic [CW-1:0] cnt_lim;

    assign en_any = en_bank_a | en_bank_b;

    pgc_sense_mask #(.NUM_A(NUM_A), .NUM_B(NUM_B)) u_mask (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_bank_a   (en_bank_a),
        .en_bank_b   (en_bank_b),
        .en_sense_a5 (en_sense_a5),
        .en_pin_b3   (en_pin_b3),
        .sink_low_a  (sink_low_a),
        .sink_low_b  (sink_low_b),
        .mon_any     (mon_any),
        .set_change  (set_change)
    );

    assign cnt_lim = (state == ST_BOOST || state == ST_FALL_QUAL) ? fall_count : rise_count;

    pgc_qual_cnt #(.CW(CW)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .inc   (cnt_inc),
        .limit (cnt_lim),
        .hit   (cnt_hit)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        cnt_clr  = 1'b1;
        cnt_inc  = 1'b0;
        if (!en_any) begin
            state_nx = ST_OFF;
        end else if (state != ST_OFF && set_change) begin
            state_nx = ST_PASS;
        end else begin
            unique case (state)
                ST_OFF: state_nx = ST_PASS;
                ST_PASS, ST_RISE_QUAL: begin
                    if (!mon_any) begin
                        state_nx = ST_PASS;
                    end else if (cnt_hit) begin
                        state_nx = ST_BOOST;
                    end else begin
                        state_nx = ST_RISE_QUAL;
                        cnt_clr  = 1'b0;
                        cnt_inc  = 1'b1;
                    end
                end
                ST_BOOST, ST_FALL_QUAL: begin
                    if (mon_any) begin
                        state_nx = ST_BOOST;
                    end else if (cnt_hit) begin
                        state_nx = ST_PASS;
                    end else begin
                        state_nx = ST_FALL_QUAL;
                        cnt_clr  = 1'b0;
                        cnt_inc  = 1'b1;
                    end
                end
                default: state_nx = ST_OFF;
            endcase
        end
    end

    always_comb begin
        gain_boost = 1'b0;
        pump_on    = 1'b1;
        unique case (state)
            ST_OFF:                 pump_on    = 1'b0;
            ST_PASS, ST_RISE_QUAL:  gain_boost = 1'b0;
            ST_BOOST, ST_FALL_QUAL: gain_boost = 1'b1;
            default:                pump_on    = 1'b0;
        endcase
    end

    assert_off_when_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !en_any |=> (!pump_on && !gain_boost));

    assert_no_spurious_boost_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!gain_boost && !mon_any) |=> !gain_boost);

    assert_hold_while_flagged_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (gain_boost && mon_any && en_any && !set_change) |=> gain_boost);

    assert_set_change_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pump_on && en_any && set_change) |=> (pump_on && !gain_boost));
endmodule

// File: tb/pump_gain_ctrl_tb.sv
module pump_gain_ctrl_tb;
    localparam time CLK_PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en_a = 0, en_b = 0, en_a5 = 0, en_b3 = 0;
    logic [4:0] fa = '0;
    logic [2:0] fb = '0;
    logic [7:0] rc = 8'd4, fc = 8'd10;
    logic       gain_boost, pump_on;

    int    n_checks = 0;
    int    n_fail = 0;
    string req = "R1";
    bit    done = 0;

    // reference model state
    bit m_on = 0, m_boost = 0;
    int m_run = 0;
    bit [7:0] m_prev = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pump_gain_ctrl u_dut (
        .clk(clk), .rst_n(rst_n),
        .en_bank_a(en_a), .en_bank_b(en_b),
        .en_sense_a5(en_a5), .en_pin_b3(en_b3),
        .sink_low_a(fa), .sink_low_b(fb),
        .rise_count(rc), .fall_count(fc),
        .gain_boost(gain_boost), .pump_on(pump_on)
    );

    function automatic bit [7:0] watched();
        bit [7:0] w = '0;
        for (int i = 0; i < 4; i++) w[i] = en_a;
        w[4] = en_a && en_a5;
        w[5] = en_b;
        w[6] = en_b;
        w[7] = en_b && en_b3;
        return w;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        bit [7:0] w;
        bit any;
        int lim;
        if (!rst_n) begin
            m_on = 0; m_boost = 0; m_run = 0; m_prev = '0;
        end else begin
            w   = watched();
            any = |(w & {fb, fa});
            if (!(en_a || en_b)) begin
                m_on = 0; m_boost = 0; m_run = 0;
            end else if (!m_on) begin
                m_on = 1; m_boost = 0; m_run = 0;
            end else if (w != m_prev) begin
                m_boost = 0; m_run = 0;
            end else if (!m_boost) begin
                lim = (rc == 0) ? 1 : int'(rc);
                if (any) begin
                    m_run++;
                    if (m_run >= lim) begin m_boost = 1; m_run = 0; end
                end else m_run = 0;
            end else begin
                lim = (fc == 0) ? 1 : int'(fc);
                if (!any) begin
                    m_run++;
                    if (m_run >= lim) begin m_boost = 0; m_run = 0; end
                end else m_run = 0;
            end
            m_prev = w;
        end
    end

    always @(negedge clk) begin
        if (!done) begin
            n_checks++;
            if (pump_on !== m_on || gain_boost !== m_boost) begin
                n_fail++;
                $display("FAIL %s: pump_on=%b gain_boost=%b expected pump_on=%b gain_boost=%b at %0t",
                         req, pump_on, gain_boost, m_on, m_boost, $time);
            end
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: run did not finish, expected completion");
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        req = "R1"; fa = 5'h1F; fb = 3'h7; en_a = 1;
        cyc(4);
        @(negedge clk); rst_n = 1; fa = '0; fb = '0; en_a = 0;
        req = "R2"; cyc(3);
        en_a = 1; cyc(4);
        req = "R3"; fa = 5'b00001; cyc(3); fa = '0; cyc(3);
        fa = 5'b00100; cyc(6);
        req = "R4"; fa = '0; cyc(5); fa = 5'b00010; cyc(1); fa = '0; cyc(12);
        req = "R5"; fb = 3'b011; cyc(10); fb = '0;
        en_b = 1; en_b3 = 0; cyc(2); en_a = 0; cyc(2);
        fa = 5'h0F; cyc(8); fa = '0; cyc(2); en_a = 1; cyc(2);
        req = "R6"; en_a5 = 0; fa = 5'b10000; cyc(10);
        en_a5 = 1; cyc(8); fa = '0; cyc(12);
        req = "R7"; fb = 3'b100; cyc(8); en_b3 = 1; cyc(8);
        fb = '0; cyc(4); fb = 3'b100; cyc(2); fb = '0; cyc(12);
        req = "R8"; fc = 8'd30; fa = 5'b01000; cyc(6); fa = '0; cyc(5);
        en_b3 = 0; cyc(3); fa = 5'b01000; cyc(2); en_a5 = 0; cyc(6); fa = '0; cyc(3);
        req = "R9"; rc = 8'd0; fc = 8'd0; fb = 3'b001; cyc(2); fb = '0; cyc(2);
        fb = 3'b010; cyc(1); fb = '0; cyc(3);
        req = "R2"; rc = 8'd2; fc = 8'd3; fa = 5'h1; cyc(4);
        en_a = 0; en_b = 0; cyc(4); fa = '0; en_b = 1; cyc(3);
        req = "R1"; fb = 3'b001; cyc(4); rst_n = 0; cyc(3); rst_n = 1; fb = '0; cyc(4);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule